// File: doc/BRIEF.md
# Infrared Remote Pulse-Frame Transmitter

This block drives the LED of an infrared remote for a toy vehicle. At a fixed frame rate it sends a packet of twelve segments. Six of them are carrier bursts and six are silent gaps, and they alternate. The bursts come in this order: a start burst, a vehicle-select burst, then one burst each for right, left, forward and backward.

Each direction burst carries one bit through its length. It is long when its button is held and short when it is not. Bursts are sent as a square-wave carrier with a 50 % duty cycle. Gaps, and the idle time after the final gap, keep the LED dark.

Lengths are counted in carrier periods. With the defaults, a 100 MHz clock divided by 2778 gives a carrier of about 36 kHz. A packet starts every 10 000 000 cycles, which is 10 per second. Button levels are captured once at the start of each packet and held until it ends. Debouncing and decoding at the receiver are outside this block.

Top module: `ir_pulse_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `led_drive` is 0. The reset is synchronous and active high.
- R2: Inside a burst the carrier period is PERIOD_CYC clock cycles. The LED is high for the first PERIOD_CYC/2 cycles of each period and low for the rest. Carrier periods are counted from the start of the packet.
- R3: The twelve segments are numbered 0 to 11. Even numbers are bursts and odd numbers are gaps, in this order: start (START_LEN periods), gap, select (SELECT_LEN), gap, right, gap, left, gap, forward, gap, backward, gap. Every gap lasts GAP_LEN periods.
- R4: `led_drive` is 0 for every cycle of every gap.
- R5: After the final gap the block is idle, with `led_drive` at 0, until the next packet start.
- R6: A packet starts on the first clock edge at which `rst` is low, and again every FRAME_CYC cycles after that. `led_drive` lags the internal sequence by one register stage. It is 0 in the first cycle after a start edge, and the first carrier-high cycle follows.
- R7: A direction burst lasts MARK_LONG periods when its button (`btn_right`, `btn_left`, `btn_fwd`, `btn_back`) is 1 at the packet start, and MARK_SHORT periods when it is 0.
- R8: The button levels are taken only at the packet start edge. A change during a packet has no effect on that packet's burst lengths.
- R9: The sequencer moves to the next segment only at the end of a carrier period or on a packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| btn_right | input | 1 | Right button level, 1 = pressed |
| btn_left | input | 1 | Left button level, 1 = pressed |
| btn_fwd | input | 1 | Forward button level, 1 = pressed |
| btn_back | input | 1 | Backward button level, 1 = pressed |
| led_drive | output | 1 | Infrared LED drive, 1 = LED on |

## Verification
The assertions assume three things about the setup:
- The button inputs are already synchronous to `clk`.
- Every length is at least one period, and PERIOD_CYC is at least 2.
- FRAME_CYC is longer than the longest possible packet, so a new start never cuts into a packet that is still running.

The bench uses a small configuration, with a 4-cycle carrier and a 200-cycle frame, whose longest packet is 148 cycles. It changes the buttons only just after a clock edge, and each time it flips them in the middle of a packet. Every one of the 16 button combinations is compared cycle by cycle against a waveform that the bench computes from the segment lengths.

// File: rtl/ir_tx_pkg.sv
`timescale 1ns/1ps
package ir_tx_pkg;
  localparam int unsigned NUM_SEG = 12;
  localparam int unsigned SEG_W   = 4;
  localparam int unsigned NUM_DIR = 4;

  typedef logic [SEG_W-1:0] seg_idx_t;

  typedef enum logic [1:0] {
    K_START,
    K_SELECT,
    K_DIR,
    K_GAP
  } seg_kind_e;

  // Even segment numbers carry a burst, odd ones are gaps.
  function automatic logic seg_is_burst(seg_idx_t s);
    return ~s[0];
  endfunction

  function automatic logic seg_is_last(seg_idx_t s);
    return s == SEG_W'(NUM_SEG - 1);
  endfunction

  function automatic seg_kind_e seg_kind(seg_idx_t s);
    if (s[0])                   return K_GAP;
    else if (s == SEG_W'(0))    return K_START;
    else if (s == SEG_W'(2))    return K_SELECT;
    else                        return K_DIR;
  endfunction

  // Segments 4, 6, 8 and 10 map to direction 0 (right) through 3 (backward).
  function automatic logic [1:0] seg_dir(seg_idx_t s);
    seg_idx_t off;
    off = s - SEG_W'(4);
    return off[2:1];
  endfunction
endpackage

// File: rtl/ir_frame_timer.sv
`timescale 1ns/1ps
module ir_frame_timer #(
  parameter int unsigned FRAME_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic frame_start
);
  localparam int unsigned FW = $clog2(FRAME_CYC);

  logic [FW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                             cnt <= '0;
    else if (cnt == FW'(FRAME_CYC - 1))  cnt <= '0;
    else                                 cnt <= cnt + FW'(1);
  end

  // The counter rests at zero during reset, so the first live edge starts a packet.
  assign frame_start = (cnt == '0);
endmodule

// File: rtl/ir_carrier_gen.sv
`timescale 1ns/1ps
module ir_carrier_gen #(
  parameter int unsigned PERIOD_CYC = 2778
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic carrier_hi,
  output logic period_end
);
  localparam int unsigned CW   = $clog2(PERIOD_CYC);
  localparam int unsigned HALF = PERIOD_CYC / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= '0;
    else if (period_end)  cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign period_end = (cnt == CW'(PERIOD_CYC - 1));
  assign carrier_hi = (cnt < CW'(HALF));
endmodule

// File: rtl/ir_frame_seq.sv
`timescale 1ns/1ps
module ir_frame_seq
  import ir_tx_pkg::*;
#(
  parameter int unsigned START_LEN  = 192,
  parameter int unsigned SELECT_LEN = 22,
  parameter int unsigned MARK_LONG  = 44,
  parameter int unsigned MARK_SHORT = 22,
  parameter int unsigned GAP_LEN    = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               period_end,
  input  logic [NUM_DIR-1:0] btn,
  output logic               busy,
  output seg_idx_t           seg,
  output logic [NUM_DIR-1:0] btn_held,
  output logic               burst_on
);
  localparam int unsigned M0 = (START_LEN > SELECT_LEN) ? START_LEN : SELECT_LEN;
  localparam int unsigned M1 = (MARK_LONG > MARK_SHORT) ? MARK_LONG : MARK_SHORT;
  localparam int unsigned M2 = (M0 > M1) ? M0 : M1;
  localparam int unsigned MAX_LEN = (M2 > GAP_LEN) ? M2 : GAP_LEN;
  localparam int unsigned LW = $clog2(MAX_LEN + 1);

  logic [LW-1:0] rem;

  // Length of a segment minus one, so that a zero count marks its last period.
  function automatic logic [LW-1:0] len_m1(seg_idx_t s, logic [NUM_DIR-1:0] b);
    logic [LW-1:0] v;
    unique case (seg_kind(s))
      K_START:  v = LW'(START_LEN - 1);
      K_SELECT: v = LW'(SELECT_LEN - 1);
      K_DIR:    v = b[seg_dir(s)] ? LW'(MARK_LONG - 1) : LW'(MARK_SHORT - 1);
      default:  v = LW'(GAP_LEN - 1);
    endcase
    return v;
  endfunction

  seg_idx_t seg_nx;
  assign seg_nx = seg + SEG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      seg      <= '0;
      rem      <= '0;
      btn_held <= '0;
    end else if (frame_start) begin
      busy     <= 1'b1;
      seg      <= '0;
      rem      <= len_m1('0, btn);
      btn_held <= btn;
    end else if (busy && period_end) begin
      if (rem == '0) begin
        if (seg_is_last(seg)) begin
          busy <= 1'b0;
        end else begin
          seg <= seg_nx;
          rem <= len_m1(seg_nx, btn_held);
        end
      end else begin
        rem <= rem - LW'(1);
      end
    end
  end

  assign burst_on = busy && seg_is_burst(seg);
endmodule

// File: rtl/ir_led_gate.sv
`timescale 1ns/1ps
module ir_led_gate (
  input  logic clk,
  input  logic rst,
  input  logic burst_on,
  input  logic carrier_hi,
  output logic led
);
  // Registered so that the LED pin sees no decode glitches.
  always_ff @(posedge clk) begin
    if (rst) led <= 1'b0;
    else     led <= burst_on && carrier_hi;
  end
endmodule

// File: rtl/ir_pulse_tx.sv
`timescale 1ns/1ps
module ir_pulse_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 2778,
  parameter int unsigned FRAME_CYC  = 10_000_000,
  parameter int unsigned START_LEN  = 192,
  parameter int unsigned SELECT_LEN = 22,
  parameter int unsigned MARK_LONG  = 44,
  parameter int unsigned MARK_SHORT = 22,
  parameter int unsigned GAP_LEN    = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_right,
  input  logic btn_left,
  input  logic btn_fwd,
  input  logic btn_back,
  output logic led_drive
);
  logic               frame_start;
  logic               period_end;
  logic               carrier_hi;
  logic               busy;
  logic               burst_on;
  seg_idx_t           seg;
  logic [NUM_DIR-1:0] btn_held;
  logic [NUM_DIR-1:0] btn_vec;

  // Bit 0 is right, bit 1 left, bit 2 forward and bit 3 backward, matching the burst order.
  assign btn_vec = {btn_back, btn_fwd, btn_left, btn_right};

  ir_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start)
  );

  ir_carrier_gen #(.PERIOD_CYC(PERIOD_CYC)) u_carrier (
    .clk        (clk),
    .rst        (rst),
    .restart    (frame_start),
    .carrier_hi (carrier_hi),
    .period_end (period_end)
  );

  ir_frame_seq #(
    .START_LEN  (START_LEN),
    .SELECT_LEN (SELECT_LEN),
    .MARK_LONG  (MARK_LONG),
    .MARK_SHORT (MARK_SHORT),
    .GAP_LEN    (GAP_LEN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .period_end  (period_end),
    .btn         (btn_vec),
    .busy        (busy),
    .seg         (seg),
    .btn_held    (btn_held),
    .burst_on    (burst_on)
  );

  ir_led_gate u_led (
    .clk        (clk),
    .rst        (rst),
    .burst_on   (burst_on),
    .carrier_hi (carrier_hi),
    .led        (led_drive)
  );
endmodule

// File: rtl/ir_pulse_tx_chk.sv
`timescale 1ns/1ps
module ir_pulse_tx_chk
  import ir_tx_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               led_drive,
  input logic               frame_start,
  input logic               period_end,
  input logic               carrier_hi,
  input logic               busy,
  input seg_idx_t           seg,
  input logic [NUM_DIR-1:0] btn_held
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the LED is dark on the cycle after any reset edge.
  always_ff @(posedge clk) begin
    if (rst_d == 1'b1) begin
      p_reset_dark_r1: assert (!led_drive);
    end
  end

  p_carrier_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !carrier_hi |=> !led_drive);

  p_seg_range_r3: assert property (@(posedge clk) disable iff (rst)
    seg < SEG_W'(NUM_SEG));

  p_gap_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !seg_is_burst(seg)) |=> !led_drive);

  p_idle_dark_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !led_drive);

  p_start_seg0_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (busy && seg == '0));

  p_btn_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(btn_held));

  p_step_on_period_r9: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !period_end) |=> ($stable(seg) && $stable(busy)));
endmodule

bind ir_pulse_tx ir_pulse_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .led_drive   (led_drive),
  .frame_start (frame_start),
  .period_end  (period_end),
  .carrier_hi  (carrier_hi),
  .busy        (busy),
  .seg         (seg),
  .btn_held    (btn_held)
);

// File: tb/sim_ir_pulse_tx.sv
`timescale 1ns/1ps
module sim_ir_pulse_tx;
  localparam int P     = 4;
  localparam int FRAME = 200;
  localparam int LSTA  = 6;
  localparam int LSEL  = 3;
  localparam int LLONG = 4;
  localparam int LSHRT = 2;
  localparam int LGAP  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_r = 1'b0, b_l = 1'b0, b_f = 1'b0, b_b = 1'b0;
  logic led;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ir_pulse_tx #(
    .PERIOD_CYC (P),
    .FRAME_CYC  (FRAME),
    .START_LEN  (LSTA),
    .SELECT_LEN (LSEL),
    .MARK_LONG  (LLONG),
    .MARK_SHORT (LSHRT),
    .GAP_LEN    (LGAP)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .btn_right (b_r),
    .btn_left  (b_l),
    .btn_fwd   (b_f),
    .btn_back  (b_b),
    .led_drive (led)
  );

  task automatic set_btn(input logic [3:0] p);
    b_r = p[0]; b_l = p[1]; b_f = p[2]; b_b = p[3];
  endtask

  // R3 / R7: segment lengths in carrier periods.
  function automatic int seg_len(input int s, input logic [3:0] p);
    if (s % 2 == 1) return LGAP;
    if (s == 0)     return LSTA;
    if (s == 2)     return LSEL;
    return p[(s - 4) / 2] ? LLONG : LSHRT;
  endfunction

  // Segment occupying a carrier period; 12 means idle.
  function automatic int seg_at(input logic [3:0] p, input int per);
    int acc = 0;
    for (int s = 0; s < 12; s++) begin
      acc += seg_len(s, p);
      if (per < acc) return s;
    end
    return 12;
  endfunction

  task automatic check(input string tag, input int k, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle=%0d led=%0b expected=%0b", tag, k, act, exp);
    end
  endtask

  // Runs n cycles from a start edge; buttons flip mid-packet to exercise R8.
  task automatic run_frame(input logic [3:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      int j, s, ph;
      logic e;
      string tag;
      @(posedge clk); #1;
      if (k == 0) begin
        e = 1'b0; tag = "R6 first cycle after start";
      end else begin
        j  = k - 1;
        s  = seg_at(p, j / P);
        ph = j % P;
        e  = (s < 12) && (s % 2 == 0) && (ph < P / 2);
        if (s == 12)      tag = "R5 idle";
        else if (s % 2)   tag = "R4 gap";
        else if (s >= 4)  tag = "R7/R8/R2 direction burst";
        else              tag = "R3/R2/R9 start-select burst";
      end
      check(tag, k, led, e);
      if (k == 7) set_btn(~p);
    end
  endtask

  initial begin
    set_btn(4'b0000);
    repeat (3) begin
      @(posedge clk); #1;
      check("R1 in reset", 0, led, 1'b0);
    end
    set_btn(4'b0000);
    rst = 1'b0;
    for (int pat = 0; pat < 16; pat++) begin
      set_btn(4'(pat));
      run_frame(4'(pat), FRAME);
    end
    // Reset in the middle of a packet, then resume.
    set_btn(4'b0101);
    run_frame(4'b0101, 30);
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check("R1 reset mid-packet", 0, led, 1'b0);
    end
    set_btn(4'b1010);
    rst = 1'b0;
    run_frame(4'b1010, FRAME);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule